// File: doc/BRIEF.md
# Per-Line Backdrop Color Fetcher

This block supplies the backdrop color. The backdrop is what the display shows wherever no other layer covers a pixel. Software programs a two-word configuration register. It holds a mode bit and the start of a color table in video memory. Timing logic pulses `line_start` during horizontal blanking before each line, and gives the index of the next line, the scan mode and the field parity.

On that pulse the block computes the byte address of one 16-bit table entry. It sends the address on a single-beat request/valid read port and waits for the returned data. It then widens the 15-bit RGB entry to 24 bits and holds that color on `bg_rgb` until the next fetch completes.

In per-line mode the table entry is chosen by the scan mode:
- In progressive scan, each line has its own entry.
- In single-density interlace, two lines share one entry.
- In double-density interlace, both fields are interleaved into one table.

In single-color mode, every line reads the first entry of the table.

Top module: `bgline_fetch`

## Requirements
- R1: After reset, `mem_req` is 0, `bg_rgb` is 0, and both configuration words read as zero: the first fetch goes to byte address 0 in single-color mode.
- R2: A `line_start` pulse while no fetch is outstanding raises `mem_req` for exactly one cycle, in the cycle after the pulse. `mem_addr` is valid in that cycle.
- R3: In per-line mode with `scan_mode` 0 (progressive; code 3 acts the same), the address is `((base + line) mod 2^19) * 2`. Here `base` is the 19-bit table field.
- R4: In per-line mode with `scan_mode` 1 (single-density interlace), the address is `(base + floor(line/2)) * 2`.
- R5: In per-line mode with `scan_mode` 2 (double-density interlace), the address is `(base + 2*line + field_odd) * 2`.
- R6: When the mode bit is 0 (single color), the address is `base * 2` whatever the line, scan mode or field.
- R7: A returned entry has blue in bits 14:10, green in 9:5 and red in 4:0. Bit 15 is ignored. `bg_rgb` = {red,3'b0, green,3'b0, blue,3'b0}, with red in bits 23:16 and blue in bits 7:0.
- R8: `bg_rgb` changes only in the cycle after `mem_rvalid` is accepted for an outstanding fetch. It holds its value between fetches.
- R9: A `line_start` that arrives while a fetch is outstanding is ignored: it issues no request.
- R10: A write with `cfg_wr_upper`=1 sets the mode bit from data bit 15 and base[18:16] from data bits 2:0. Data bits 14:3 are ignored. A write with `cfg_wr_upper`=0 sets base[15:0].
- R11: With parameter `VRAM_4MBIT`=1, bit 19 of `mem_addr` is always 0. The other bits are unchanged.
- R12: A `mem_rvalid` that arrives while no fetch is outstanding leaves `bg_rgb` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_upper | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_wr_data | input | 16 | Configuration write data |
| line_start | input | 1 | Fetch trigger pulse, in blanking before a line |
| line_num | input | LINE_W | Index of the next line (within its field when interlaced) |
| scan_mode | input | 2 | 0 progressive, 1 single-density interlace, 2 double-density interlace |
| field_odd | input | 1 | Current field parity |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Table entry |
| bg_rgb | output | 24 | Backdrop color |

## Verification
`mem_req` and `mem_addr` are due one clock edge after the edge that samples `line_start`. The color is due one edge after the edge that samples `mem_rvalid`. Configuration writes take effect one edge after the write strobe.

Each scenario task drives its inputs on the falling edge and waits the counted number of edges. It samples on the falling edge that follows:
- the request and address one half-period after the edge that registered them;
- the color before the data edge, to confirm it is held, and again just after.

Ignore cases are checked in the cycles that follow the ignored input, before any new stimulus.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
    localparam int BASE_W  = 19;
    localparam int ENTRY_W = 16;
    localparam int COMP_W  = 5;
    localparam int CHAN_W  = 8;
    localparam int RGB_W   = 3 * CHAN_W;

    typedef enum logic [1:0] {
        SCAN_PROG   = 2'd0,
        SCAN_SINGLE = 2'd1,
        SCAN_DOUBLE = 2'd2,
        SCAN_RSVD   = 2'd3
    } scan_e;

    typedef struct packed {
        logic              per_line;
        logic [BASE_W-1:0] base;
    } bg_cfg_t;
endpackage

// File: rtl/bgf_cfg_regs.sv
module bgf_cfg_regs
    import bgf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_upper,
    input  logic [ENTRY_W-1:0]  wr_data,
    output bg_cfg_t             cfg
);
    localparam int LO_W = 16;
    localparam int HI_W = BASE_W - LO_W;

    bg_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_upper) begin
                cfg_d.per_line          = wr_data[ENTRY_W-1];
                cfg_d.base[BASE_W-1:LO_W] = wr_data[HI_W-1:0];
            end else begin
                cfg_d.base[LO_W-1:0]    = wr_data[LO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen
    import bgf_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int ADDR_W     = 20,
    parameter bit VRAM_4MBIT = 1'b0
) (
    input  bg_cfg_t             cfg,
    input  logic [1:0]          scan_mode,
    input  logic [LINE_W-1:0]   line_num,
    input  logic                field_odd,
    output logic [ADDR_W-1:0]   byte_addr
);
    localparam int IDX_W  = LINE_W + 1;
    localparam int WORD_W = ADDR_W - 1;

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word_addr;
    logic [ADDR_W-1:0] raw_addr;

    always_comb begin
        case (scan_mode)
            SCAN_SINGLE: idx = IDX_W'(line_num >> 1);
            SCAN_DOUBLE: idx = {line_num, field_odd};
            default:     idx = {1'b0, line_num};
        endcase
        if (!cfg.per_line) idx = '0;
        word_addr = WORD_W'(cfg.base) + WORD_W'(idx);
        raw_addr  = {word_addr, 1'b0};
    end

    generate
        if (VRAM_4MBIT) begin : g_small
            assign byte_addr = {1'b0, raw_addr[ADDR_W-2:0]};
        end else begin : g_full
            assign byte_addr = raw_addr;
        end
    endgenerate
endmodule

// File: rtl/bgf_unpack.sv
module bgf_unpack
    import bgf_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    output logic [RGB_W-1:0]   rgb
);
    localparam int PAD_W = CHAN_W - COMP_W;

    generate
        for (genvar c = 0; c < 3; c++) begin : g_chan
            assign rgb[(2-c)*CHAN_W +: CHAN_W] = {entry[c*COMP_W +: COMP_W], {PAD_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/bgline_fetch.sv
module bgline_fetch
    import bgf_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int ADDR_W     = 20,
    parameter bit VRAM_4MBIT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic                cfg_wr_upper,
    input  logic [15:0]         cfg_wr_data,
    input  logic                line_start,
    input  logic [LINE_W-1:0]   line_num,
    input  logic [1:0]          scan_mode,
    input  logic                field_odd,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [15:0]         mem_rdata,
    output logic [23:0]         bg_rgb
);
    typedef struct packed {
        logic              busy;
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [RGB_W-1:0]  rgb;
    } fetch_st_t;

    bg_cfg_t           cfg;
    logic [ADDR_W-1:0] addr_next;
    logic [RGB_W-1:0]  rgb_next;
    fetch_st_t         st_d, st_q;

    bgf_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_upper (cfg_wr_upper),
        .wr_data  (cfg_wr_data),
        .cfg      (cfg)
    );

    bgf_addr_gen #(
        .LINE_W     (LINE_W),
        .ADDR_W     (ADDR_W),
        .VRAM_4MBIT (VRAM_4MBIT)
    ) u_addr (
        .cfg       (cfg),
        .scan_mode (scan_mode),
        .line_num  (line_num),
        .field_odd (field_odd),
        .byte_addr (addr_next)
    );

    bgf_unpack u_unpack (
        .entry (mem_rdata),
        .rgb   (rgb_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (!st_q.busy && line_start) begin
            st_d.busy = 1'b1;
            st_d.req  = 1'b1;
            st_d.addr = addr_next;
        end
        if (st_q.busy && mem_rvalid) begin
            st_d.busy = 1'b0;
            st_d.rgb  = rgb_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req  = st_q.req;
    assign mem_addr = st_q.addr;
    assign bg_rgb   = st_q.rgb;
endmodule

// File: rtl/bgf_checker.sv
module bgf_checker #(
    parameter int ADDR_W     = 20,
    parameter bit VRAM_4MBIT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [15:0]       mem_rdata,
    input logic [23:0]       bg_rgb
);
    assert_req_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !busy) |=> mem_req);

    assert_req_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_no_req_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($past(line_start) && !$past(busy)));

    assert_addr_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    assert_rgb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && mem_rvalid) |=> $stable(bg_rgb));

    assert_red_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid) |=> (bg_rgb[23:16] == {$past(mem_rdata[4:0]), 3'b000}));

    generate
        if (VRAM_4MBIT) begin : g_small
            assert_top_bit_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
                mem_req |-> !mem_addr[ADDR_W-1]);
        end
    endgenerate
endmodule

bind bgline_fetch bgf_checker #(
    .ADDR_W     (ADDR_W),
    .VRAM_4MBIT (VRAM_4MBIT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .busy       (st_q.busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .bg_rgb     (bg_rgb)
);

// File: tb/bgline_fetch_tb_top.sv
module bgline_fetch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_wr_upper = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic        line_start = 1'b0;
    logic [9:0]  line_num = '0;
    logic [1:0]  scan_mode = '0;
    logic        field_odd = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, mem_req4;
    logic [19:0] mem_addr, mem_addr4;
    logic [23:0] bg_rgb, bg_rgb4;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [18:0] base_m = '0;

    always #5 clk = ~clk;

    bgline_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_upper(cfg_wr_upper),
        .cfg_wr_data(cfg_wr_data), .line_start(line_start), .line_num(line_num),
        .scan_mode(scan_mode), .field_odd(field_odd), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .bg_rgb(bg_rgb)
    );

    bgline_fetch #(.VRAM_4MBIT(1'b1)) dut4_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_upper(cfg_wr_upper),
        .cfg_wr_data(cfg_wr_data), .line_start(line_start), .line_num(line_num),
        .scan_mode(scan_mode), .field_odd(field_odd), .mem_req(mem_req4),
        .mem_addr(mem_addr4), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .bg_rgb(bg_rgb4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] addr_of(input logic [18:0] base, input int idx);
        logic [18:0] w;
        w = base + 19'(idx);
        return {w, 1'b0};
    endfunction

    function automatic logic [23:0] rgb_of(input logic [15:0] e);
        return {e[4:0], 3'b0, e[9:5], 3'b0, e[14:10], 3'b0};
    endfunction

    task automatic write_reg(input logic upper, input logic [15:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_upper = upper; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic fetch(input int line, input logic [1:0] mode, input logic fld,
                         input logic [15:0] data, input logic [19:0] exp_addr, input string req);
        logic [23:0] prev;
        @(negedge clk);
        prev = bg_rgb;
        line_start = 1'b1; line_num = 10'(line); scan_mode = mode; field_odd = fld;
        @(negedge clk);
        line_start = 1'b0;
        check("R2 req raised", 32'(mem_req), 32'd1);
        check(req, 32'(mem_addr), 32'(exp_addr));
        mem_rvalid = 1'b1; mem_rdata = data;
        @(negedge clk);
        check("R2 req one cycle", 32'(mem_req), 32'd0);
        mem_rvalid = 1'b0;
        check("R7 color", 32'(bg_rgb), 32'(rgb_of(data)));
        if (prev == rgb_of(data)) check("R8 same", 32'(bg_rgb), 32'(prev));
    endtask

    task automatic t_reset;
        check("R1 req", 32'(mem_req), 32'd0);
        check("R1 rgb", 32'(bg_rgb), 32'd0);
        fetch(37, 2'd0, 1'b0, 16'h001F, 20'h0, "R1 cleared config addr");
    endtask

    task automatic t_progressive;
        write_reg(1'b1, 16'h8001);
        write_reg(1'b0, 16'h2345);
        base_m = 19'h12345;
        fetch(7, 2'd0, 1'b0, 16'h03E0, addr_of(base_m, 7), "R3 progressive");
        fetch(9, 2'd3, 1'b1, 16'h7C00, addr_of(base_m, 9), "R3 code3 as progressive");
        write_reg(1'b1, 16'h8007);
        write_reg(1'b0, 16'hFFFF);
        fetch(5, 2'd0, 1'b0, 16'h1234, 20'h00008, "R3 wrap");
    endtask

    task automatic t_interlace;
        write_reg(1'b1, 16'h8001);
        write_reg(1'b0, 16'h2345);
        fetch(7, 2'd1, 1'b0, 16'hFFFF, addr_of(base_m, 3), "R4 single odd line");
        fetch(6, 2'd1, 1'b1, 16'h8000, addr_of(base_m, 3), "R4 single even line");
        fetch(5, 2'd2, 1'b1, 16'h5555, addr_of(base_m, 11), "R5 double odd field");
        fetch(5, 2'd2, 1'b0, 16'h2AAA, addr_of(base_m, 10), "R5 double even field");
    endtask

    task automatic t_single_color;
        write_reg(1'b1, 16'h0001);
        fetch(100, 2'd2, 1'b1, 16'h4210, addr_of(base_m, 0), "R6 single color double");
        fetch(33, 2'd0, 1'b0, 16'h0421, addr_of(base_m, 0), "R6 single color prog");
    endtask

    task automatic t_fields;
        write_reg(1'b1, 16'h7FFA);
        base_m = 19'h22345;
        fetch(50, 2'd0, 1'b0, 16'h0001, addr_of(base_m, 0), "R10 upper bits 14:3 ignored");
        write_reg(1'b0, 16'h0010);
        base_m = 19'h20010;
        fetch(50, 2'd0, 1'b0, 16'h0002, addr_of(base_m, 0), "R10 lower word");
    endtask

    task automatic t_busy_ignore;
        logic [23:0] held;
        write_reg(1'b1, 16'h8000);
        write_reg(1'b0, 16'h0000);
        @(negedge clk);
        held = bg_rgb;
        line_start = 1'b1; line_num = 10'd4; scan_mode = 2'd0;
        @(negedge clk);
        check("R2 req raised", 32'(mem_req), 32'd1);
        @(negedge clk);
        check("R9 start while busy", 32'(mem_req), 32'd0);
        line_start = 1'b0;
        @(negedge clk);
        check("R9 no late req", 32'(mem_req), 32'd0);
        check("R8 hold while waiting", 32'(bg_rgb), 32'(held));
        mem_rvalid = 1'b1; mem_rdata = 16'h0C63;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check("R7 color after wait", 32'(bg_rgb), 32'(rgb_of(16'h0C63)));
        @(negedge clk);
        check("R9 no req after data", 32'(mem_req), 32'd0);
    endtask

    task automatic t_idle_valid;
        logic [23:0] held;
        @(negedge clk);
        held = bg_rgb;
        mem_rvalid = 1'b1; mem_rdata = 16'h7FFF;
        @(negedge clk);
        mem_rvalid = 1'b0;
        @(negedge clk);
        check("R12 idle valid ignored", 32'(bg_rgb), 32'(held));
    endtask

    task automatic t_small_vram;
        write_reg(1'b1, 16'h8004);
        write_reg(1'b0, 16'h0000);
        base_m = 19'h40000;
        fetch(0, 2'd0, 1'b0, 16'h0001, 20'h80000, "R11 full width");
        check("R11 4mbit top bit dropped", 32'(mem_addr4), 32'h00000);
        fetch(3, 2'd0, 1'b0, 16'h0002, 20'h80006, "R11 full width line3");
        check("R11 4mbit low bits", 32'(mem_addr4), 32'h00006);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_progressive();
        t_interlace();
        t_single_color();
        t_fields();
        t_busy_ignore();
        t_idle_valid();
        t_small_vram();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule